// File: doc/BRIEF.md
# Load-Linked/Store-Conditional Reservation Monitor

This block is placed in front of a memory array and decides, one request at a time, whether a store may reach the array. A load-linked request from a hardware context records a reservation for that context on a 16-byte line. A later store-conditional from the same context to the same line succeeds only if no store to that line has happened in between. A successful store-conditional writes and reports a result of 1. A failed one is suppressed and reports 0.

Each request carries an operation code, a physical address and a context number. The write-enable decision and the store-conditional result come back in the same cycle as the request. The reservation table changes on the following clock edge. The table holds a parameterised number of entries. Each context owns at most one entry. When the table is full, the oldest entry is evicted to make room for a new context.

Top module: `llsc_monitor`

## Requirements
- R1: Addresses are compared at 16-byte granularity. Bits 3:0 of `req_addr` are ignored for both recording and matching, so addresses 0x1003 and 0x100C fall on the same line and 0x3010 does not match 0x3000.
- R2: After reset, and whenever no entry is live, a store-conditional (op code 3) gives `wr_en`=0, `sc_valid`=1 and `sc_ok`=0.
- R3: A plain store (op code 2) always gives `wr_en`=1, including when the table is empty.
- R4: A store-conditional succeeds (`wr_en`=1, `sc_ok`=1) only when a live entry holds both the same line and the requesting context. An entry made by another context on that line does not count.
- R5: A successful store-conditional removes every entry on its line, including the requester's own entry. A repeated store-conditional to that line therefore fails.
- R6: A plain store removes the entries of all contexts on its line. Entries on other lines stay live.
- R7: A failed store-conditional also removes every entry on its line.
- R8: Each context holds at most one entry. A new load-linked (op code 1) from a context replaces that context's earlier line.
- R9: When all entries are live and a context without an entry issues a load-linked, the least recently recorded entry is evicted. Re-recording an entry makes it the most recent.
- R10: Plain loads (op code 0) and load-linked requests never assert `wr_en`. Plain loads leave the table unchanged.
- R11: A synchronous active-high reset invalidates every entry.
- R12: `sc_valid` is 1 only in cycles that carry a valid store-conditional. `wr_en`, `sc_valid` and `sc_ok` are 0 when `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 plain load, 1 load-linked, 2 plain store, 3 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_ctx | input | CTX_W | Requesting hardware context |
| wr_en | output | 1 | Store may write the array this cycle |
| sc_valid | output | 1 | `sc_ok` carries a store-conditional result |
| sc_ok | output | 1 | Store-conditional result: 1 success, 0 failure |

## Verification
Store-conditionals are issued against an empty table, against the same line at different byte offsets and against a neighbouring line. This separates a comparison on the full address from one on the masked line. Two contexts reserve one line, and then a plain store, a successful store-conditional or a failed store-conditional hits that line. This shows whether clearing is done by line alone or by line and context together. A fill-then-overflow sequence, with one context refreshing its entry first and a consumed entry leaving a hole, shows whether eviction follows the recording order and not the slot index or the order in which the table was first filled.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LL    = 2'd1,
    OP_STORE = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;

  // byte offset bits dropped before a line is recorded or compared
  localparam int LINE_OFS = 4;
endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 28,
  parameter int CTX_W   = 3
) (
  input  logic [ENTRIES-1:0]             valid_q,
  input  logic [ENTRIES-1:0][LINE_W-1:0] line_q,
  input  logic [ENTRIES-1:0][CTX_W-1:0]  ctx_q,
  input  logic [LINE_W-1:0]              req_line,
  input  logic [CTX_W-1:0]               req_ctx,
  output logic [ENTRIES-1:0]             line_hit,
  output logic [ENTRIES-1:0]             ctx_hit,
  output logic                           pair_hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign line_hit[g] = valid_q[g] && (line_q[g] == req_line);
    assign ctx_hit[g]  = valid_q[g] && (ctx_q[g] == req_ctx);
  end

  assign pair_hit = |(line_hit & ctx_hit);
endmodule

// File: rtl/llsc_victim_pick.sv
module llsc_victim_pick #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2,
  parameter int AGE_W   = 3
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0]            ctx_hit,
  input  logic [ENTRIES-1:0][AGE_W-1:0] age_q,
  output logic [IDX_W-1:0]              victim,
  output logic [AGE_W-1:0]              victim_age
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic             own_any, free_any;
  logic [IDX_W-1:0] own_idx, free_idx, old_idx;
  logic [AGE_W-1:0] live_cnt;

  always_comb begin
    own_any  = 1'b0;
    free_any = 1'b0;
    own_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    live_cnt = '0;
    // scan downwards so the lowest index wins
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ctx_hit[i]) begin
        own_any = 1'b1;
        own_idx = IDX_W'(i);
      end
      if (!valid_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (valid_q[i] && age_q[i] == OLDEST) old_idx = IDX_W'(i);
      if (valid_q[i]) live_cnt = live_cnt + 1'b1;
    end
  end

  always_comb begin
    if (own_any)       victim = own_idx;
    else if (free_any) victim = free_idx;
    else               victim = old_idx;
    victim_age = valid_q[victim] ? age_q[victim] : live_cnt;
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 28,
  parameter int CTX_W   = 3,
  parameter int IDX_W   = 2,
  parameter int AGE_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           do_record,
  input  logic                           do_clear,
  input  logic                           do_load,
  input  logic [LINE_W-1:0]              req_line,
  input  logic [CTX_W-1:0]               req_ctx,
  input  logic [IDX_W-1:0]               victim,
  input  logic [AGE_W-1:0]               victim_age,
  input  logic [ENTRIES-1:0]             line_hit,
  output logic [ENTRIES-1:0]             valid_q,
  output logic [ENTRIES-1:0][LINE_W-1:0] line_q,
  output logic [ENTRIES-1:0][CTX_W-1:0]  ctx_q,
  output logic [ENTRIES-1:0][AGE_W-1:0]  age_q
);
  // per entry: how many removed entries were younger than it
  logic [ENTRIES-1:0][AGE_W-1:0] drop_below;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      drop_below[i] = '0;
      for (int j = 0; j < ENTRIES; j++)
        if (line_hit[j] && age_q[j] < age_q[i]) drop_below[i] = drop_below[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      age_q   <= '0;
    end else if (do_record) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == victim) begin
          valid_q[i] <= 1'b1;
          line_q[i]  <= req_line;
          ctx_q[i]   <= req_ctx;
          age_q[i]   <= '0;
        end else if (valid_q[i] && age_q[i] < victim_age) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end else if (do_clear) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (line_hit[i])     valid_q[i] <= 1'b0;
        else if (valid_q[i]) age_q[i]   <= age_q[i] - drop_below[i];
      end
    end
  end

  // R10
  load_keeps_table_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(do_load) && !$past(rst)) |-> (valid_q == $past(valid_q) && line_q == $past(line_q)));

  for (genvar a = 0; a < ENTRIES; a++) begin : g_uniq
    for (genvar b = a + 1; b < ENTRIES; b++) begin : g_pair
      // R8
      one_per_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_q[a] && valid_q[b] && ctx_q[a] == ctx_q[b]));
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int CTX_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              wr_en,
  output logic              sc_valid,
  output logic              sc_ok
);
  import llsc_pkg::*;

  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int AGE_W  = $clog2(ENTRIES + 1);

  llsc_op_e                      op;
  logic [LINE_W-1:0]             req_line;
  logic                          is_sc, is_store, is_ll, is_load;
  logic [ENTRIES-1:0]            valid_q, line_hit, ctx_hit;
  logic [ENTRIES-1:0][LINE_W-1:0] line_q;
  logic [ENTRIES-1:0][CTX_W-1:0] ctx_q;
  logic [ENTRIES-1:0][AGE_W-1:0] age_q;
  logic                          pair_hit;
  logic [IDX_W-1:0]              victim;
  logic [AGE_W-1:0]              victim_age;

  assign op       = llsc_op_e'(req_op);
  assign req_line = req_addr[ADDR_W-1:LINE_OFS];
  assign is_sc    = req_valid && op == OP_SC;
  assign is_store = req_valid && op == OP_STORE;
  assign is_ll    = req_valid && op == OP_LL;
  assign is_load  = req_valid && op == OP_LOAD;

  llsc_line_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .CTX_W(CTX_W)) u_match (
    .valid_q(valid_q), .line_q(line_q), .ctx_q(ctx_q),
    .req_line(req_line), .req_ctx(req_ctx),
    .line_hit(line_hit), .ctx_hit(ctx_hit), .pair_hit(pair_hit)
  );

  llsc_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_pick (
    .valid_q(valid_q), .ctx_hit(ctx_hit), .age_q(age_q),
    .victim(victim), .victim_age(victim_age)
  );

  llsc_resv_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .CTX_W(CTX_W),
                    .IDX_W(IDX_W), .AGE_W(AGE_W)) u_table (
    .clk(clk), .rst(rst),
    .do_record(is_ll), .do_clear(is_sc || is_store), .do_load(is_load),
    .req_line(req_line), .req_ctx(req_ctx),
    .victim(victim), .victim_age(victim_age), .line_hit(line_hit),
    .valid_q(valid_q), .line_q(line_q), .ctx_q(ctx_q), .age_q(age_q)
  );

  assign wr_en    = is_store || (is_sc && pair_hit);
  assign sc_valid = is_sc;
  assign sc_ok    = is_sc && pair_hit;

  // R2
  sc_after_reset_fail_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && sc_valid) |-> !sc_ok);

  // R4
  ll_then_sc_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_ll) && is_sc && req_ctx == $past(req_ctx)
     && req_line == $past(req_line)) |-> (sc_ok && wr_en));

  // R6
  store_then_sc_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_store || is_sc) && is_sc
     && req_line == $past(req_line)) |-> !sc_ok);

  // R12
  result_only_sc_chk: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> (sc_valid && wr_en));
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CTX_W  = 3;
  localparam logic [1:0] LD = 2'd0, LL = 2'd1, ST = 2'd2, SC = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = LD;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic wr_en, sc_valid, sc_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  wr;
    logic  scv;
    logic  ok;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.ENTRIES(4), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ctx(req_ctx),
    .wr_en(wr_en), .sc_valid(sc_valid), .sc_ok(sc_ok)
  );

  task automatic push(logic wr, logic scv, logic ok, string tag);
    exp_t e;
    e.wr = wr; e.scv = scv; e.ok = ok; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic req(logic [1:0] op, logic [ADDR_W-1:0] a, int c,
                     logic wr, logic scv, logic ok, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_ctx = CTX_W'(c);
    push(wr, scv, ok, tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    req_valid = 1'b0; req_op = SC; req_addr = 32'h100; req_ctx = '0;
    push(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic pulse_reset();
    idle("R12 idle before reset");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: compare each cycle's outputs with the next expected item
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (wr_en !== e.wr || sc_valid !== e.scv || sc_ok !== e.ok) begin
          fails++;
          $display("FAIL %s: got wr_en=%b sc_valid=%b sc_ok=%b, expected %b %b %b",
                   e.tag, wr_en, sc_valid, sc_ok, e.wr, e.scv, e.ok);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, empty table
    idle("R12 idle output after reset");
    req(SC, 32'h0000_0100, 0, 0, 1, 0, "R2 SC on empty table");
    req(ST, 32'h0000_0200, 1, 1, 0, 0, "R3 store on empty table");
    req(LD, 32'h0000_0100, 0, 0, 0, 0, "R10 plain load no write");
    // granularity and own-entry clearing
    req(LL, 32'h0000_1003, 1, 0, 0, 0, "R10 LL no write");
    req(LD, 32'h0000_1000, 2, 0, 0, 0, "R12 load gives no result");
    req(SC, 32'h0000_100C, 1, 1, 1, 1, "R1 SC same line other offset");
    req(SC, 32'h0000_1000, 1, 0, 1, 0, "R5 repeat SC after success");
    // failed SC of another context clears the line
    req(LL, 32'h0000_2000, 1, 0, 0, 0, "R4 LL ctx1");
    req(LL, 32'h0000_2000, 2, 0, 0, 0, "R4 LL ctx2");
    req(SC, 32'h0000_2004, 3, 0, 1, 0, "R4 SC by ctx without entry");
    req(SC, 32'h0000_2000, 1, 0, 1, 0, "R7 failed SC cleared line");
    req(SC, 32'h0000_2000, 2, 0, 1, 0, "R7 failed SC cleared ctx2");
    // neighbouring line
    req(LL, 32'h0000_3000, 1, 0, 0, 0, "R1 LL line 0x300");
    req(SC, 32'h0000_3010, 1, 0, 1, 0, "R1 SC next line fails");
    req(SC, 32'h0000_300F, 1, 1, 1, 1, "R1 SC top byte of line");
    // plain stores
    req(LL, 32'h0000_4000, 1, 0, 0, 0, "R6 LL ctx1");
    req(LL, 32'h0000_4100, 2, 0, 0, 0, "R6 LL ctx2");
    req(ST, 32'h0000_5000, 3, 1, 0, 0, "R3 store other line");
    req(SC, 32'h0000_4100, 2, 1, 1, 1, "R6 unrelated store keeps entry");
    req(ST, 32'h0000_4004, 0, 1, 0, 0, "R3 store on reserved line");
    req(SC, 32'h0000_4000, 1, 0, 1, 0, "R6 store cleared entry");
    req(LL, 32'h0000_4200, 1, 0, 0, 0, "R6 LL ctx1");
    req(LL, 32'h0000_4200, 2, 0, 0, 0, "R6 LL ctx2");
    req(ST, 32'h0000_4200, 3, 1, 0, 0, "R6 third ctx store");
    req(SC, 32'h0000_4200, 1, 0, 1, 0, "R6 ctx1 cleared");
    req(SC, 32'h0000_4200, 2, 0, 1, 0, "R6 ctx2 cleared");
    // one entry per context
    req(LL, 32'h0000_6000, 2, 0, 0, 0, "R8 LL first line");
    req(LL, 32'h0000_7000, 2, 0, 0, 0, "R8 LL replaces");
    req(SC, 32'h0000_6000, 2, 0, 1, 0, "R8 old line dropped");
    req(SC, 32'h0000_7000, 2, 1, 1, 1, "R8 new line live");
    // eviction by recording order
    req(LL, 32'h0000_8000, 0, 0, 0, 0, "R9 fill ctx0");
    req(LL, 32'h0000_8100, 1, 0, 0, 0, "R9 fill ctx1");
    req(LL, 32'h0000_8200, 2, 0, 0, 0, "R9 fill ctx2");
    req(LL, 32'h0000_8300, 3, 0, 0, 0, "R9 fill ctx3");
    req(LL, 32'h0000_8000, 0, 0, 0, 0, "R9 refresh ctx0");
    req(LL, 32'h0000_8400, 4, 0, 0, 0, "R9 overflow ctx4");
    req(SC, 32'h0000_8100, 1, 0, 1, 0, "R9 oldest ctx1 evicted");
    req(SC, 32'h0000_8000, 0, 1, 1, 1, "R9 refreshed ctx0 kept");
    req(SC, 32'h0000_8200, 2, 1, 1, 1, "R9 ctx2 kept");
    req(SC, 32'h0000_8300, 3, 1, 1, 1, "R9 ctx3 kept");
    req(SC, 32'h0000_8400, 4, 1, 1, 1, "R9 ctx4 recorded");
    req(LL, 32'h0000_8000, 0, 0, 0, 0, "R9 refill ctx0");
    req(LL, 32'h0000_8100, 1, 0, 0, 0, "R9 refill ctx1");
    req(LL, 32'h0000_8200, 2, 0, 0, 0, "R9 refill ctx2");
    req(LL, 32'h0000_8300, 3, 0, 0, 0, "R9 refill ctx3");
    req(LL, 32'h0000_8500, 5, 0, 0, 0, "R9 overflow ctx5");
    req(SC, 32'h0000_8500, 5, 1, 1, 1, "R9 ctx5 consumed, hole");
    req(LL, 32'h0000_8600, 6, 0, 0, 0, "R9 ctx6 fills hole");
    req(LL, 32'h0000_8700, 7, 0, 0, 0, "R9 overflow ctx7");
    req(SC, 32'h0000_8000, 0, 0, 1, 0, "R9 ctx0 evicted earlier");
    req(SC, 32'h0000_8100, 1, 0, 1, 0, "R9 ctx1 oldest after hole");
    req(SC, 32'h0000_8200, 2, 1, 1, 1, "R9 ctx2 kept after hole");
    req(SC, 32'h0000_8700, 7, 1, 1, 1, "R9 ctx7 recorded");
    // reset clears the table
    req(LL, 32'h0000_9000, 3, 0, 0, 0, "R11 LL before reset");
    pulse_reset();
    req(SC, 32'h0000_9000, 3, 0, 1, 0, "R11 entry gone after reset");
    idle("R12 idle at end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule